// File: doc/BRIEF.md
# Dual-Lane Multiply-Accumulate Upset Checker

This block runs two identical signed multiply-accumulate lanes in lockstep. Both lanes see the same coefficient, the same data word, the same addend and the same controls. In every cycle each lane forms a new 44-bit accumulator value from five parts: its previous value, a carry-in bit, a 44-bit addend, and the signed product of two 18-bit operands, which is added or subtracted. The previous value can be shifted arithmetically right by 17 places before it is added. It can also be dropped to start a fresh sum. Each lane flags a signed wrap of its 44-bit result.

A registered comparator watches the two lane accumulators. When they disagree it raises a mismatch flag one cycle later. This lets a system detect a state upset in one copy of the arithmetic. A per-lane fault-injection input inverts the least significant bit of one lane's next result, so the detection path can be exercised. Lane 0 drives the result and overflow outputs.

Top module: `dual_mac_checker`

## Requirements
- R1: On a rising clock edge with `rst_n` low, the accumulator output, the overflow flag and the mismatch flag all become 0.
- R2: With `sub_en` low, the accumulator visible after a clock edge equals feedback + `cin` + `c_in` + `a_in`×`b_in`, all treated as signed two's-complement values and kept to 44 bits.
- R3: With `sub_en` high, the product is subtracted instead: feedback + `cin` + `c_in` − `a_in`×`b_in`.
- R4: With `clr` high, the feedback term is 0, so the sum restarts from the other terms.
- R5: With `shr_en` high and `clr` low, the feedback term is the previous accumulator shifted arithmetically right by 17 bits. `clr` takes priority over `shr_en`.
- R6: `ovf_out` is registered with the accumulator. It is 1 exactly when the true signed sum of that update lies outside the signed 44-bit range, in which case the stored value is the wrapped result.
- R7: Both lanes receive identical inputs. `p_out` and `ovf_out` show lane 0. With no fault injected, `mismatch` stays 0.
- R8: `mismatch` is 1 in the cycle after the two lane accumulators differ. It returns to 0 one cycle after they agree again.
- R9: `fault_inj[i]` high at a clock edge inverts bit 0 of lane i's new accumulator. A fault on lane 0 is visible on `p_out`. A fault on lane 1 is not visible on `p_out`, but it is reported through `mismatch`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| a_in | input | 18 | Signed multiplier operand (shared coefficient) |
| b_in | input | 18 | Signed multiplicand operand (data stream) |
| c_in | input | 44 | Signed addend |
| cin | input | 1 | Carry-in added at bit 0 |
| sub_en | input | 1 | 1: subtract the product, 0: add it |
| shr_en | input | 1 | Arithmetic right shift of feedback by 17 |
| clr | input | 1 | Replace the feedback term with 0 |
| fault_inj | input | 2 | Per-lane LSB inversion of the next result |
| p_out | output | 44 | Lane 0 accumulator |
| ovf_out | output | 1 | Lane 0 signed-wrap flag for the last update |
| mismatch | output | 1 | Registered lane disagreement flag |

## Verification
The accumulator and overflow flag are due one clock edge after their inputs are presented. The mismatch flag is due one edge later still, because it registers a comparison of registered values. The bench drives inputs on the falling edge and samples just after the following rising edge. It checks `p_out` and `ovf_out` at that point. For mismatch it waits one more edge after a fault is applied, and one more after the lanes are realigned. While the shared vector table runs, mismatch is checked every cycle to confirm it stays at 0.

// File: rtl/dmac_pkg.sv
// Package: widths shared by the dual-lane multiply-accumulate checker.
// Assumes the product width fits inside the accumulator width.
package dmac_pkg;
    localparam int A_W    = 18;   // multiplier operand width
    localparam int B_W    = 18;   // multiplicand operand width
    localparam int ACC_W  = 44;   // addend and accumulator width
    localparam int SHR_N  = 17;   // feedback shift amount
    localparam int LANES  = 2;    // redundant lane count
endpackage

// File: rtl/dmac_lane.sv
// Module: one multiply-accumulate lane.
// Forms fb + cin + c +/- a*b in a widened signed sum, stores the low ACC_W
// bits and flags a signed wrap. Assumes ACC_W > A_W + B_W.
module dmac_lane #(
    parameter int A_W   = 18,
    parameter int B_W   = 18,
    parameter int ACC_W = 44,
    parameter int SHR_N = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [A_W-1:0]   a,
    input  logic [B_W-1:0]   b,
    input  logic [ACC_W-1:0] c,
    input  logic             cin,
    input  logic             sub,
    input  logic             shr,
    input  logic             clr,
    input  logic             flip,
    output logic [ACC_W-1:0] p_q,
    output logic             ovf_q
);
    localparam int PROD_W = A_W + B_W;
    localparam int SUM_W  = ACC_W + 2;

    logic signed [PROD_W-1:0] prod;
    logic signed [ACC_W-1:0]  fb;
    logic signed [SUM_W-1:0]  prod_x, term_x, fb_x, c_x, cin_x, sum;
    logic [SUM_W-ACC_W:0]     top;
    logic                     wrap;
    logic [ACC_W-1:0]         p_nxt;

    // Purpose: select the feedback term and form the widened signed sum.
    always_comb begin
        prod   = $signed(a) * $signed(b);
        if (clr)
            fb = '0;
        else if (shr)
            fb = $signed(p_q) >>> SHR_N;
        else
            fb = $signed(p_q);
        prod_x = {{(SUM_W-PROD_W){prod[PROD_W-1]}}, prod};
        term_x = sub ? -prod_x : prod_x;
        fb_x   = {{(SUM_W-ACC_W){fb[ACC_W-1]}}, fb};
        c_x    = {{(SUM_W-ACC_W){c[ACC_W-1]}}, c};
        cin_x  = {{(SUM_W-1){1'b0}}, cin};
        sum    = fb_x + c_x + cin_x + term_x;
        top    = sum[SUM_W-1:ACC_W-1];
        wrap   = !((&top) || (~|top));
        p_nxt  = sum[ACC_W-1:0] ^ {{(ACC_W-1){1'b0}}, flip};
    end

    // Purpose: register the accumulator and its wrap flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_q   <= '0;
            ovf_q <= 1'b0;
        end else begin
            p_q   <= p_nxt;
            ovf_q <= wrap;
        end
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (p_q == '0 && !ovf_q)); // R1

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !shr && !cin && !flip && c == '0 && (a == '0 || b == '0))
        |=> ($stable(p_q) && !ovf_q)); // R2
endmodule

// File: rtl/dmac_cmp.sv
// Module: registered lane comparator.
// Flags, one cycle late, any lane whose accumulator differs from lane 0.
// Assumes all lanes share the clock and reset.
module dmac_cmp #(
    parameter int ACC_W = 44,
    parameter int LANES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] p_lane [LANES],
    output logic             mis_q
);
    logic [LANES-1:0] diff;

    // Purpose: mark each lane that disagrees with lane 0.
    generate
        for (genvar i = 0; i < LANES; i++) begin : g_diff
            if (i == 0) begin : g_ref
                assign diff[i] = 1'b0;
            end else begin : g_cmp
                assign diff[i] = (p_lane[i] != p_lane[0]);
            end
        end
    endgenerate

    // Purpose: register the combined disagreement.
    always_ff @(posedge clk) begin
        if (!rst_n) mis_q <= 1'b0;
        else        mis_q <= |diff;
    end
endmodule

// File: rtl/dual_mac_checker.sv
// Module: top of the dual-lane multiply-accumulate checker.
// Two identical lanes share every input except their fault-injection bit.
// Lane 0 drives the outputs. Assumes LANES >= 2.
module dual_mac_checker
    import dmac_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [A_W-1:0]   a_in,
    input  logic [B_W-1:0]   b_in,
    input  logic [ACC_W-1:0] c_in,
    input  logic             cin,
    input  logic             sub_en,
    input  logic             shr_en,
    input  logic             clr,
    input  logic [LANES-1:0] fault_inj,
    output logic [ACC_W-1:0] p_out,
    output logic             ovf_out,
    output logic             mismatch
);
    logic [ACC_W-1:0] p_lane   [LANES];
    logic [LANES-1:0] ovf_lane;
    logic             all_same;

    // Purpose: instantiate the redundant lanes.
    generate
        for (genvar i = 0; i < LANES; i++) begin : g_lane
            dmac_lane #(.A_W(A_W), .B_W(B_W), .ACC_W(ACC_W), .SHR_N(SHR_N)) u_lane (
                .clk   (clk),
                .rst_n (rst_n),
                .a     (a_in),
                .b     (b_in),
                .c     (c_in),
                .cin   (cin),
                .sub   (sub_en),
                .shr   (shr_en),
                .clr   (clr),
                .flip  (fault_inj[i]),
                .p_q   (p_lane[i]),
                .ovf_q (ovf_lane[i])
            );
        end
    endgenerate

    dmac_cmp #(.ACC_W(ACC_W), .LANES(LANES)) u_cmp (
        .clk    (clk),
        .rst_n  (rst_n),
        .p_lane (p_lane),
        .mis_q  (mismatch)
    );

    // Purpose: lane 0 is the reported result.
    assign p_out   = p_lane[0];
    assign ovf_out = ovf_lane[0];

    // Purpose: true when every lane holds the same accumulator.
    always_comb begin
        all_same = 1'b1;
        for (int i = 1; i < LANES; i++)
            if (p_lane[i] != p_lane[0]) all_same = 1'b0;
    end

    AST_FAULT_CAUGHT: assert property (@(posedge clk) disable iff (!rst_n)
        ($onehot(fault_inj) && all_same) |=> ##1 mismatch); // R9

    AST_RISE_NEEDS_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mismatch) |-> ($past(fault_inj, 2) != '0)); // R8
endmodule

// File: tb/dual_mac_checker_bench.sv
module dual_mac_checker_bench;
    localparam int AW = 18;
    localparam int CW = 44;

    typedef struct packed {
        logic [AW-1:0] a;
        logic [AW-1:0] b;
        logic [CW-1:0] c;
        logic          ci;
        logic          sub;
        logic          shr;
        logic          clr;
        logic [CW-1:0] exp_p;
        logic          exp_ovf;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t TBL [NV] = '{
        // R2 R4: load 1 + 10 + 3*4
        '{18'd3, 18'd4, 44'd10, 1'b1, 1'b0, 1'b0, 1'b1, 44'd23, 1'b0},
        // R2: accumulate 2*5
        '{18'd2, 18'd5, 44'd0, 1'b0, 1'b0, 1'b0, 1'b0, 44'd33, 1'b0},
        // R3: subtract 3*3, add 1
        '{18'd3, 18'd3, 44'd1, 1'b0, 1'b1, 1'b0, 1'b0, 44'd25, 1'b0},
        // R2: negative operand -2*7
        '{18'h3FFFE, 18'd7, 44'd0, 1'b0, 1'b0, 1'b0, 1'b0, 44'd11, 1'b0},
        // R3: subtract negative product
        '{18'h3FFFE, 18'd7, 44'd0, 1'b0, 1'b1, 1'b0, 1'b0, 44'd25, 1'b0},
        // R4: load 2^20
        '{18'd0, 18'd0, 44'd1048576, 1'b0, 1'b0, 1'b0, 1'b1, 44'd1048576, 1'b0},
        // R5: 2^20 >>> 17 = 8, plus 5
        '{18'd0, 18'd0, 44'd5, 1'b0, 1'b0, 1'b1, 1'b0, 44'd13, 1'b0},
        // R4: load -262144
        '{18'd0, 18'd0, 44'hFFFFFFC0000, 1'b0, 1'b0, 1'b0, 1'b1, 44'hFFFFFFC0000, 1'b0},
        // R5: arithmetic shift keeps sign: -2
        '{18'd0, 18'd0, 44'd0, 1'b0, 1'b0, 1'b1, 1'b0, 44'hFFFFFFFFFFE, 1'b0},
        // R5: clr wins over shr; largest product 2^34
        '{18'h20000, 18'h20000, 44'd0, 1'b0, 1'b0, 1'b1, 1'b1, 44'h00400000000, 1'b0},
        // R6: positive wrap
        '{18'd0, 18'd0, 44'h7FFFFFFFFFF, 1'b1, 1'b0, 1'b0, 1'b1, 44'h80000000000, 1'b1},
        // R6: flag clears
        '{18'd0, 18'd0, 44'd0, 1'b0, 1'b0, 1'b0, 1'b1, 44'd0, 1'b0},
        // R6: negative wrap
        '{18'd1, 18'd1, 44'h80000000000, 1'b0, 1'b1, 1'b0, 1'b1, 44'h7FFFFFFFFFF, 1'b1}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] a_in = '0, b_in = '0;
    logic [CW-1:0] c_in = '0;
    logic          cin = 1'b0, sub_en = 1'b0, shr_en = 1'b0, clr = 1'b0;
    logic [1:0]    fault_inj = '0;
    logic [CW-1:0] p_out;
    logic          ovf_out, mismatch;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    dual_mac_checker u_dual_mac_checker (
        .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in), .c_in(c_in),
        .cin(cin), .sub_en(sub_en), .shr_en(shr_en), .clr(clr),
        .fault_inj(fault_inj), .p_out(p_out), .ovf_out(ovf_out),
        .mismatch(mismatch)
    );

    task automatic chk(input string tag, input logic [CW-1:0] act, input logic [CW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input vec_t v, input logic [1:0] f);
        @(negedge clk);
        a_in = v.a; b_in = v.b; c_in = v.c; cin = v.ci;
        sub_en = v.sub; shr_en = v.shr; clr = v.clr; fault_inj = f;
        @(posedge clk);
        #1;
    endtask

    initial begin
        for (int w = 0; w < 5000; w++) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset p_out", p_out, '0);
        chk("R1 reset ovf_out", {43'd0, ovf_out}, '0);
        chk("R1 reset mismatch", {43'd0, mismatch}, '0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            drive(TBL[i], 2'b00);
            chk($sformatf("R2-table p_out vec %0d", i), p_out, TBL[i].exp_p);
            chk($sformatf("R6 ovf_out vec %0d", i), {43'd0, ovf_out}, {43'd0, TBL[i].exp_ovf});
            chk($sformatf("R7 mismatch quiet vec %0d", i), {43'd0, mismatch}, '0);
        end

        // R9: fault on lane 1 stays off p_out
        drive(TBL[0], 2'b10);
        chk("R9 lane1 fault hidden", p_out, 44'd23);
        drive(TBL[0], 2'b00);
        chk("R8 mismatch rises", {43'd0, mismatch}, 44'd1);
        drive(TBL[0], 2'b00);
        chk("R8 mismatch falls", {43'd0, mismatch}, '0);

        // R9: fault on lane 0 is visible
        drive(TBL[0], 2'b01);
        chk("R9 lane0 fault visible", p_out, 44'd22);
        drive(TBL[0], 2'b00);
        chk("R8 mismatch after lane0 fault", {43'd0, mismatch}, 44'd1);
        chk("R4 realigned p_out", p_out, 44'd23);
        drive(TBL[0], 2'b00);
        chk("R8 mismatch cleared", {43'd0, mismatch}, '0);

        // R1: reset mid-run clears a pending mismatch and a set overflow
        drive(TBL[10], 2'b01);
        chk("R9 fault on wrapped value", p_out, 44'h80000000001);
        chk("R6 ovf set before reset", {43'd0, ovf_out}, 44'd1);
        @(negedge clk);
        rst_n = 1'b0;
        fault_inj = 2'b00;
        @(posedge clk);
        #1;
        chk("R1 mid reset p_out", p_out, '0);
        chk("R1 mid reset ovf_out", {43'd0, ovf_out}, '0);
        chk("R1 mid reset mismatch", {43'd0, mismatch}, '0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule